// File: doc/BRIEF.md
# Register Write-Pending Hazard Scoreboard

This block tracks which architectural registers have a write outstanding. Each register owns one pending bit. When a function unit issues an instruction that will write a register, it raises that register's bit in its own set lane. When a writeback port writes the register file, it raises the matching bit in its own clear lane. The lanes of each kind are OR-merged. Clear wins over set on the same bit in the same cycle.

The vector comes out in two forms. The live view already includes this cycle's set and clear requests. The delayed view is the register contents, so it equals the live view from one cycle earlier.

Read requesters check the live view through their own register-select masks, and an overall issue-time flag covers all read masks together. Write-after-write requesters check the delayed view. An instruction issuing in this cycle therefore never sees its own newly raised bit as a conflict.

Top module: `wpend_scoreboard`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `pend_now`, `pend_dly` and every hazard output are 0 while no requests are driven.
- R2: A bit raised in any set lane in cycle N shows on `pend_now` in cycle N and on `pend_dly` from cycle N+1. `pend_dly` always equals `pend_now` of the previous cycle.
- R3: A pending bit with no clear request holds its value over any number of cycles.
- R4: A bit raised in any clear lane drops on `pend_now` in the same cycle and on `pend_dly` one cycle later.
- R5: When set and clear are both requested for the same bit in the same cycle, the bit reads 0 on `pend_now` and 0 on `pend_dly` in the next cycle.
- R6: Set requests from all lanes are OR-merged, and so are clear requests. Lane i occupies bits [i*NUM_REGS +: NUM_REGS] of `set_req`, `clr_req`, `rd_mask` and `waw_mask`, and bit j of a lane selects register j.
- R7: `rd_hazard[k]` is 1 exactly when `pend_now` ANDed with read mask k is nonzero.
- R8: `issue_hazard` is 1 exactly when `pend_now` ANDed with the OR of all read masks is nonzero.
- R9: `waw_hazard[k]` is 1 exactly when `pend_dly` ANDed with write-after-write mask k is nonzero. A bit set in the current cycle does not raise it.
- R10: A clear in cycle N does not remove a write-after-write hazard in cycle N. The hazard falls in cycle N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_req | input | NUM_SETTERS*NUM_REGS | Per-function-unit set lanes (issue time) |
| clr_req | input | NUM_CLEARERS*NUM_REGS | Per-writeback-port clear lanes |
| rd_mask | input | NUM_RD_REQ*NUM_REGS | Per-read-requester register-select masks |
| waw_mask | input | NUM_WAW_REQ*NUM_REGS | Per-write-requester register-select masks |
| pend_now | output | NUM_REGS | Live pending vector, includes this cycle's requests |
| pend_dly | output | NUM_REGS | Registered pending vector |
| rd_hazard | output | NUM_RD_REQ | Per-requester read-after-write hazard |
| issue_hazard | output | 1 | Hazard over the union of all read masks |
| waw_hazard | output | NUM_WAW_REQ | Per-requester write-after-write hazard |

## Verification
The hardest case to reach from the ports is the same cycle in which a requester both sets a register and tests it for a write-after-write conflict. Here the live and delayed views disagree, and only the delayed one may be used. The stimulus drives a set lane and a matching write-after-write mask in the same half cycle, checks that the hazard stays low, and checks again one edge later, when it must rise. Clear against a standing hazard is handled the same way. A random-traffic phase then compares every output with a reference model kept in the bench, including cycles where set and clear collide on a bit.

// File: rtl/wpend_pkg.sv
package wpend_pkg;
    localparam int unsigned DEF_NUM_REGS     = 32;
    localparam int unsigned DEF_NUM_SETTERS  = 4;
    localparam int unsigned DEF_NUM_CLEARERS = 3;
    localparam int unsigned DEF_NUM_RD_REQ   = 3;
    localparam int unsigned DEF_NUM_WAW_REQ  = 2;
endpackage

// File: rtl/wpend_lane_merge.sv
module wpend_lane_merge #(
    parameter int unsigned LANES = 2,
    parameter int unsigned WIDTH = 8
) (
    input  logic [LANES*WIDTH-1:0] lanes,
    output logic [WIDTH-1:0]       merged
);
    logic [WIDTH-1:0] acc [LANES+1];

    assign acc[0] = '0;
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign acc[i+1] = acc[i] | lanes[i*WIDTH +: WIDTH];
    end
    assign merged = acc[LANES];
endmodule

// File: rtl/wpend_vec.sv
module wpend_vec #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_bits,
    input  logic [WIDTH-1:0] clr_bits,
    output logic [WIDTH-1:0] live_view,
    output logic [WIDTH-1:0] held_view
);
    typedef struct packed {
        logic [WIDTH-1:0] pend;
    } vec_state_t;

    vec_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.pend = (state_q.pend | set_bits) & ~clr_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign live_view = state_d.pend;
    assign held_view = state_q.pend;

    // R5: a bit cleared in the previous cycle is 0 in the register now
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((state_q.pend & $past(clr_bits)) == '0));

    // R3: bits not cleared keep their value
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(state_q.pend) & ~$past(clr_bits) & ~state_q.pend) == '0));

    // R2: a set without a clear lands in the register
    a_r2_set_lands: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(set_bits) & ~$past(clr_bits) & ~state_q.pend) == '0));
endmodule

// File: rtl/wpend_hazard_filter.sv
module wpend_hazard_filter #(
    parameter int unsigned NUM_REQ = 2,
    parameter int unsigned WIDTH   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [WIDTH-1:0]         view,
    input  logic [NUM_REQ*WIDTH-1:0] masks,
    output logic [NUM_REQ-1:0]       flags,
    output logic                     any_flag
);
    logic [WIDTH-1:0] mask_union;

    wpend_lane_merge #(.LANES(NUM_REQ), .WIDTH(WIDTH)) u_union (
        .lanes  (masks),
        .merged (mask_union)
    );

    for (genvar k = 0; k < NUM_REQ; k++) begin : g_req
        assign flags[k] = |(view & masks[k*WIDTH +: WIDTH]);

        // R7: a hazard flag never rises with an empty mask
        a_r7_needs_mask: assert property (@(posedge clk) disable iff (rst)
            flags[k] |-> (|masks[k*WIDTH +: WIDTH]));
    end

    assign any_flag = |(view & mask_union);

    // R8: the union flag agrees with the per-requester flags
    a_r8_union_matches: assert property (@(posedge clk) disable iff (rst)
        any_flag == (|flags));
endmodule

// File: rtl/wpend_scoreboard.sv
module wpend_scoreboard #(
    parameter int unsigned NUM_REGS     = wpend_pkg::DEF_NUM_REGS,
    parameter int unsigned NUM_SETTERS  = wpend_pkg::DEF_NUM_SETTERS,
    parameter int unsigned NUM_CLEARERS = wpend_pkg::DEF_NUM_CLEARERS,
    parameter int unsigned NUM_RD_REQ   = wpend_pkg::DEF_NUM_RD_REQ,
    parameter int unsigned NUM_WAW_REQ  = wpend_pkg::DEF_NUM_WAW_REQ
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_SETTERS*NUM_REGS-1:0]   set_req,
    input  logic [NUM_CLEARERS*NUM_REGS-1:0]  clr_req,
    input  logic [NUM_RD_REQ*NUM_REGS-1:0]    rd_mask,
    input  logic [NUM_WAW_REQ*NUM_REGS-1:0]   waw_mask,
    output logic [NUM_REGS-1:0]               pend_now,
    output logic [NUM_REGS-1:0]               pend_dly,
    output logic [NUM_RD_REQ-1:0]             rd_hazard,
    output logic                              issue_hazard,
    output logic [NUM_WAW_REQ-1:0]            waw_hazard
);
    logic [NUM_REGS-1:0] set_any;
    logic [NUM_REGS-1:0] clr_any;
    logic                waw_any;

    wpend_lane_merge #(.LANES(NUM_SETTERS), .WIDTH(NUM_REGS)) u_set_merge (
        .lanes  (set_req),
        .merged (set_any)
    );

    wpend_lane_merge #(.LANES(NUM_CLEARERS), .WIDTH(NUM_REGS)) u_clr_merge (
        .lanes  (clr_req),
        .merged (clr_any)
    );

    wpend_vec #(.WIDTH(NUM_REGS)) u_vec (
        .clk       (clk),
        .rst       (rst),
        .set_bits  (set_any),
        .clr_bits  (clr_any),
        .live_view (pend_now),
        .held_view (pend_dly)
    );

    wpend_hazard_filter #(.NUM_REQ(NUM_RD_REQ), .WIDTH(NUM_REGS)) u_rd_filter (
        .clk      (clk),
        .rst      (rst),
        .view     (pend_now),
        .masks    (rd_mask),
        .flags    (rd_hazard),
        .any_flag (issue_hazard)
    );

    wpend_hazard_filter #(.NUM_REQ(NUM_WAW_REQ), .WIDTH(NUM_REGS)) u_waw_filter (
        .clk      (clk),
        .rst      (rst),
        .view     (pend_dly),
        .masks    (waw_mask),
        .flags    (waw_hazard),
        .any_flag (waw_any)
    );

    // R2: the delayed view is the live view one cycle late
    a_r2_delay: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pend_dly == $past(pend_now)));

    // R1: the cycle after reset, the held vector is empty
    a_r1_reset_empty: assert property (@(posedge clk)
        (!rst && $past(rst)) |-> (pend_dly == '0));

    // R9: a waw hazard needs a bit pending since the previous cycle
    a_r9_waw_delayed: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && waw_any) |-> (|$past(pend_now)));
endmodule

// File: tb/wpend_scoreboard_bench.sv
module wpend_scoreboard_bench;
    localparam int R  = 32;
    localparam int NS = 4;
    localparam int NC = 3;
    localparam int NR = 3;
    localparam int NW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NS*R-1:0] set_req  = '0;
    logic [NC*R-1:0] clr_req  = '0;
    logic [NR*R-1:0] rd_mask  = '0;
    logic [NW*R-1:0] waw_mask = '0;
    logic [R-1:0]    pend_now, pend_dly;
    logic [NR-1:0]   rd_hazard;
    logic            issue_hazard;
    logic [NW-1:0]   waw_hazard;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wpend_scoreboard #(
        .NUM_REGS(R), .NUM_SETTERS(NS), .NUM_CLEARERS(NC),
        .NUM_RD_REQ(NR), .NUM_WAW_REQ(NW)
    ) u_wpend_scoreboard (
        .clk(clk), .rst(rst), .set_req(set_req), .clr_req(clr_req),
        .rd_mask(rd_mask), .waw_mask(waw_mask), .pend_now(pend_now),
        .pend_dly(pend_dly), .rd_hazard(rd_hazard),
        .issue_hazard(issue_hazard), .waw_hazard(waw_hazard)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        set_req = '0; clr_req = '0; rd_mask = '0; waw_mask = '0;
    endtask

    // move to the next negative edge, then let combinational paths settle
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle_inputs();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(pend_now == '0, "R1 pend_now", 64'(pend_now), 0);
        chk(pend_dly == '0, "R1 pend_dly", 64'(pend_dly), 0);
        rd_mask = '1; waw_mask = '1; #1;
        chk(rd_hazard == '0 && !issue_hazard && waw_hazard == '0, "R1 hazards",
            64'({rd_hazard, issue_hazard, waw_hazard}), 0);
        idle_inputs();
    endtask

    task automatic t_set_timing();
        set_req[2*R + 5] = 1'b1;
        waw_mask[1*R + 5] = 1'b1;
        rd_mask[0*R + 5]  = 1'b1;
        #1;
        chk(pend_now[5] == 1'b1, "R2 live same cycle", 64'(pend_now), 64'h20);
        chk(pend_dly[5] == 1'b0, "R2 delayed not yet", 64'(pend_dly), 0);
        chk(rd_hazard == 3'b001, "R7 read hazard on live set", 64'(rd_hazard), 1);
        chk(waw_hazard == 2'b00, "R9 no self waw", 64'(waw_hazard), 0);
        step();
        set_req = '0;
        #1;
        chk(pend_dly[5] == 1'b1, "R2 delayed next cycle", 64'(pend_dly), 64'h20);
        chk(waw_hazard == 2'b10, "R9 waw after one cycle", 64'(waw_hazard), 2);
    endtask

    task automatic t_hold();
        repeat (3) step();
        chk(pend_now == 32'h20 && pend_dly == 32'h20, "R3 hold",
            64'(pend_dly), 64'h20);
    endtask

    task automatic t_clear();
        clr_req[1*R + 5] = 1'b1;
        #1;
        chk(pend_now[5] == 1'b0, "R4 live clear same cycle", 64'(pend_now), 0);
        chk(pend_dly[5] == 1'b1, "R4 delayed still set", 64'(pend_dly), 64'h20);
        chk(waw_hazard == 2'b10, "R10 waw stays during clear", 64'(waw_hazard), 2);
        chk(rd_hazard == 3'b000, "R7 read hazard drops on clear", 64'(rd_hazard), 0);
        step();
        clr_req = '0;
        #1;
        chk(pend_dly == '0, "R4 delayed cleared", 64'(pend_dly), 0);
        chk(waw_hazard == 2'b00, "R10 waw falls next cycle", 64'(waw_hazard), 0);
        idle_inputs();
    endtask

    task automatic t_conflict();
        set_req[0*R + 9] = 1'b1;
        clr_req[2*R + 9] = 1'b1;
        #1;
        chk(pend_now[9] == 1'b0, "R5 clear wins live", 64'(pend_now), 0);
        step();
        idle_inputs();
        #1;
        chk(pend_dly[9] == 1'b0, "R5 clear wins held", 64'(pend_dly), 0);
    endtask

    task automatic t_merge();
        set_req[0*R + 1] = 1'b1;
        set_req[3*R + 2] = 1'b1;
        set_req[1*R + 31] = 1'b1;
        step();
        set_req = '0;
        #1;
        chk(pend_dly == 32'h8000_0006, "R6 set lanes merged", 64'(pend_dly),
            64'h8000_0006);
        clr_req[0*R + 1]  = 1'b1;
        clr_req[2*R + 31] = 1'b1;
        step();
        clr_req = '0;
        #1;
        chk(pend_dly == 32'h0000_0004, "R6 clear lanes merged", 64'(pend_dly), 4);
    endtask

    task automatic t_issue();
        rd_mask[0*R +: R] = 32'h0000_0001;
        rd_mask[1*R +: R] = 32'h0000_0010;
        #1;
        chk(!issue_hazard && rd_hazard == '0, "R8 no overlap",
            64'({rd_hazard, issue_hazard}), 0);
        rd_mask[2*R +: R] = 32'h0000_0004;
        #1;
        chk(issue_hazard && rd_hazard == 3'b100, "R8 one mask overlaps",
            64'({rd_hazard, issue_hazard}), 64'h9);
        rd_mask = '0;
        clr_req[0*R + 2] = 1'b1;
        step();
        idle_inputs();
        #1;
        chk(pend_dly == '0, "R4 emptied", 64'(pend_dly), 0);
    endtask

    task automatic t_random();
        logic [R-1:0] mq = '0;
        for (int cyc = 0; cyc < 400; cyc++) begin
            logic [R-1:0] s_or, c_or, e_now, r_or;
            logic [NR-1:0] e_rd;
            logic [NW-1:0] e_waw;
            chk(pend_dly == mq, "R2 random delayed", 64'(pend_dly), 64'(mq));
            s_or = '0; c_or = '0; r_or = '0;
            for (int i = 0; i < NS; i++) begin
                logic [R-1:0] v = $urandom & $urandom & $urandom;
                set_req[i*R +: R] = v; s_or |= v;
            end
            for (int i = 0; i < NC; i++) begin
                logic [R-1:0] v = $urandom & $urandom & $urandom;
                clr_req[i*R +: R] = v; c_or |= v;
            end
            for (int i = 0; i < NR; i++) begin
                logic [R-1:0] v = $urandom & $urandom;
                rd_mask[i*R +: R] = v; r_or |= v;
            end
            for (int i = 0; i < NW; i++) waw_mask[i*R +: R] = $urandom & $urandom;
            #1;
            e_now = (mq | s_or) & ~c_or;
            for (int i = 0; i < NR; i++) e_rd[i] = |(e_now & rd_mask[i*R +: R]);
            for (int i = 0; i < NW; i++) e_waw[i] = |(mq & waw_mask[i*R +: R]);
            chk(pend_now == e_now, "R5 random live", 64'(pend_now), 64'(e_now));
            chk(rd_hazard == e_rd, "R7 random read", 64'(rd_hazard), 64'(e_rd));
            chk(issue_hazard == |(e_now & r_or), "R8 random issue",
                64'(issue_hazard), 64'(|(e_now & r_or)));
            chk(waw_hazard == e_waw, "R9 random waw", 64'(waw_hazard), 64'(e_waw));
            mq = e_now;
            @(negedge clk);
        end
        idle_inputs();
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_set_timing();
                t_hold();
                t_clear();
                t_conflict();
                t_merge();
                t_issue();
                @(negedge clk);
                t_random();
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    checks++;
                    fails++;
                    $display("FAIL watchdog actual=running expected=done");
                end
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule